// File: doc/BRIEF.md
# Programmable Comma Word Aligner

This block sits behind a deserializer. It takes a parallel word stream whose word boundary is unknown and finds that boundary by searching for a programmable alignment pattern. The pattern is usually a 10-bit comma. The search runs over a two-word window: the previous valid word in the low half and the current valid word in the high half. Because of this, a pattern that straddles two words is still found. The pattern length is selectable, and the match can be exact or can also accept the bitwise inverse. The inverse option lets a single setting catch both running-disparity forms of a comma.

On the first match the block locks the bit offset and raises its sync flag. From then on every output word is the window shifted right by the locked offset, so the pattern lands in the least significant bits. While the lock is held, matches at other offsets do not move the boundary. A one-cycle realign request or a reset drops the lock and starts a fresh search.

Top module: `comma_word_aligner`

## Requirements
- R1: `pat_len_sel` picks the compared length: 0 gives 7 bits, 1 gives 8, 2 gives 10, 3 gives 16, 4 gives 20, and 5, 6 or 7 give 32. Only that many low bits of `pat_value` take part in the comparison.
- R2: When `cmp_en` is 0, only the programmed pattern counts as a match. Its inverse does not.
- R3: When `cmp_en` is 1, both the programmed pattern and its bitwise inverse count as a match.
- R4: The search window is {current word, previous word}, with the previous word in bits W-1:0. Candidate offsets run from 0 to W-1. A pattern that spans the two words is found.
- R5: When several offsets match in one window, the lowest offset is chosen.
- R6: The output word is the window shifted right by the chosen offset, taken W bits wide. It is registered on the next valid beat after the later word of the window arrives, so each word comes out two valid beats after it enters.
- R7: On the beat that first finds a match, `sync_ok` rises, `pat_det` pulses, and the output already carries the pattern in its low bits.
- R8: While locked, the offset does not change. A match that appears only at another offset gives no detect and does not move the boundary.
- R9: While locked, `pat_det` is high for one cycle after each valid beat whose window matches at the locked offset. It is low at all other times.
- R10: A high `realign` clears the lock, and `sync_ok` is low in the next cycle. If `realign` coincides with a valid beat, that beat is output at offset 0 and cannot lock.
- R11: When `in_valid` is low, the input word is ignored, `out_data` holds its value, and `pat_det` is low.
- R12: After reset, and before the first lock, `out_data` is the window at offset 0 (all zero out of reset), `pat_det` stays low and `sync_ok` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word qualifier |
| in_data | input | W | Unaligned input word |
| pat_value | input | 32 | Alignment pattern, low bits used |
| pat_len_sel | input | 3 | Pattern length code |
| cmp_en | input | 1 | Also accept inverted pattern |
| realign | input | 1 | Drop lock and search again |
| out_data | output | W | Aligned output word |
| pat_det | output | 1 | Pattern seen at the locked offset |
| sync_ok | output | 1 | Boundary locked |

## Verification
One comma stream is run through the block under complement matching. The comma is placed at an offset, then its inverse is placed at another offset, then the inverse at the locked offset. Each check separates the effect of locking from the effect of a later match. The sequence goes on with realign and a valid gap, which shows that the offset is re-acquired and that state holds across idle cycles. Directed windows then show the following:
- a pattern straddling two words, which the window search must handle;
- two patterns in one word, which only lowest-offset priority resolves;
- an inverted pattern with complement matching off, which exact mode must reject;
- one window per length code, each with junk in the unused pattern bits, which shows masking at every length.

// File: rtl/comma_word_aligner.sv
module comma_word_aligner #(
  parameter int W    = 32,
  parameter int SELW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [W-1:0]    in_data,
  input  logic [31:0]     pat_value,
  input  logic [SELW-1:0] pat_len_sel,
  input  logic            cmp_en,
  input  logic            realign,
  output logic [W-1:0]    out_data,
  output logic            pat_det,
  output logic            sync_ok
);
  localparam int PW = 32;
  localparam int OW = $clog2(W);
  localparam int WW = 2 * W;

  logic [W-1:0]  cur_q, prev_q;
  logic [WW-1:0] win;
  logic [PW-1:0] mask, pat_m, pat_n;
  logic [W-1:0]  hit;
  logic          found, locked;
  logic [OW-1:0] first, off_q, off_use;
  logic [WW-1:0] shifted;

  always_comb begin
    case (pat_len_sel)
      3'd0:    mask = 32'h0000_007F;
      3'd1:    mask = 32'h0000_00FF;
      3'd2:    mask = 32'h0000_03FF;
      3'd3:    mask = 32'h0000_FFFF;
      3'd4:    mask = 32'h000F_FFFF;
      default: mask = 32'hFFFF_FFFF;
    endcase
  end

  assign win   = {cur_q, prev_q};
  assign pat_m = pat_value & mask;
  assign pat_n = ~pat_value & mask;

  for (genvar k = 0; k < W; k++) begin : g_cand
    logic [PW-1:0] cand;
    assign cand   = win[k +: PW] & mask;
    assign hit[k] = (cand == pat_m) || (cmp_en && (cand == pat_n));
  end

  always_comb begin
    found = 1'b0;
    first = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (hit[i]) begin
        found = 1'b1;
        first = OW'(i);
      end
    end
  end

  assign off_use = locked ? off_q : (found ? first : '0);
  assign shifted = win >> off_use;
  assign sync_ok = locked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q    <= '0;
      prev_q   <= '0;
      out_data <= '0;
      pat_det  <= 1'b0;
      locked   <= 1'b0;
      off_q    <= '0;
    end else begin
      pat_det <= 1'b0;
      if (realign) locked <= 1'b0;
      if (in_valid) begin
        prev_q <= cur_q;
        cur_q  <= in_data;
        if (realign) begin
          out_data <= win[W-1:0];
        end else if (locked) begin
          out_data <= shifted[W-1:0];
          pat_det  <= hit[off_q];
        end else if (found) begin
          locked   <= 1'b1;
          off_q    <= first;
          out_data <= shifted[W-1:0];
          pat_det  <= 1'b1;
        end else begin
          out_data <= win[W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/comma_word_aligner_chk.sv
module comma_word_aligner_chk #(
  parameter int W  = 32,
  parameter int OW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          realign,
  input logic [W-1:0]  out_data,
  input logic          pat_det,
  input logic          sync_ok,
  input logic [OW-1:0] off_q
);
  // R9
  det_needs_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pat_det |-> sync_ok);

  // R7
  lock_shows_det_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_ok) |-> pat_det);

  // R10
  realign_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    realign |=> !sync_ok);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_data) && !pat_det));

  // R8
  lock_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_ok && !realign) |=> (sync_ok && $stable(off_q)));

  // R12
  no_idle_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_ok && !in_valid) |=> !sync_ok);
endmodule

bind comma_word_aligner comma_word_aligner_chk #(.W(W), .OW(OW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .realign(realign),
  .out_data(out_data), .pat_det(pat_det), .sync_ok(sync_ok), .off_q(off_q)
);

// File: tb/comma_word_aligner_bench.sv
module comma_word_aligner_bench;
  localparam int W = 32;
  localparam int NTV = 15;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [W-1:0]  in_data = '0;
  logic [31:0]   pat_value = '0;
  logic [2:0]    pat_len_sel = '0;
  logic          cmp_en = 1'b0;
  logic          realign = 1'b0;
  logic [W-1:0]  out_data;
  logic          pat_det;
  logic          sync_ok;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  comma_word_aligner #(.W(W)) u_comma_word_aligner (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .pat_value(pat_value), .pat_len_sel(pat_len_sel), .cmp_en(cmp_en),
    .realign(realign), .out_data(out_data), .pat_det(pat_det), .sync_ok(sync_ok)
  );

  // {valid, realign, din, exp_out, exp_det, exp_sync}; pattern 0x17C, 10 bits, complement on
  localparam logic [67:0] TV [NTV] = '{
    {1'b1, 1'b0, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0},
    {1'b1, 1'b0, 32'h0000_2F80, 32'h0000_0000, 1'b0, 1'b0},
    {1'b1, 1'b0, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0},
    {1'b1, 1'b0, 32'h0028_3000, 32'h0000_017C, 1'b1, 1'b1},
    {1'b1, 1'b0, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b1},
    {1'b1, 1'b0, 32'h0000_5060, 32'h0001_4180, 1'b0, 1'b1},
    {1'b1, 1'b0, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b1},
    {1'b1, 1'b0, 32'h0000_0000, 32'h0000_0283, 1'b1, 1'b1},
    {1'b1, 1'b1, 32'h0002_F800, 32'h0000_0000, 1'b0, 1'b0},
    {1'b1, 1'b0, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0},
    {1'b1, 1'b0, 32'h0000_0000, 32'h0000_017C, 1'b1, 1'b1},
    {1'b0, 1'b0, 32'hFFFF_FFFF, 32'h0000_017C, 1'b0, 1'b1},
    {1'b1, 1'b0, 32'h0002_F800, 32'h0000_0000, 1'b0, 1'b1},
    {1'b1, 1'b0, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b1},
    {1'b1, 1'b0, 32'h0000_0000, 32'h0000_017C, 1'b1, 1'b1}
  };

  task automatic check(string tag, logic [W-1:0] eo, logic ed, logic es);
    tests++;
    if (out_data !== eo || pat_det !== ed || sync_ok !== es) begin
      fails++;
      $display("FAIL %s: out=%h/%h det=%b/%b sync=%b/%b (actual/expected)",
               tag, out_data, eo, pat_det, ed, sync_ok, es);
    end
  endtask

  task automatic beat(logic [W-1:0] d, logic v, logic r);
    in_data  = d;
    in_valid = v;
    realign  = r;
    @(negedge clk);
    in_valid = 1'b0;
    realign  = 1'b0;
  endtask

  task automatic do_reset(logic [31:0] p, logic [2:0] s, logic c);
    rst_n = 1'b0;
    pat_value = p;
    pat_len_sel = s;
    cmp_en = c;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic window(string tag, logic [31:0] p, logic [2:0] s, logic c,
                        logic [W-1:0] d0, logic [W-1:0] d1,
                        logic [W-1:0] eo, logic ed, logic es);
    do_reset(p, s, c);
    beat(d0, 1'b1, 1'b0);
    beat(d1, 1'b1, 1'b0);
    beat('0, 1'b1, 1'b0);
    check(tag, eo, ed, es);
  endtask

  initial begin
    do_reset(32'h0000_017C, 3'd2, 1'b1);
    check("R12 reset state", '0, 1'b0, 1'b0);

    // R6 R7 R8 R9 R10 R11 R3 along the table
    for (int i = 0; i < NTV; i++) begin
      beat(TV[i][65:34], TV[i][67], TV[i][66]);
      check($sformatf("R6/R8/R9/R10/R11 vector %0d", i), TV[i][33:2], TV[i][1], TV[i][0]);
    end

    window("R4 straddling pattern", 32'h17C, 3'd2, 1'b0, 32'hC000_0000, 32'h17,
           32'h0000_017C, 1'b1, 1'b1);
    window("R5 lowest offset wins", 32'h17C, 3'd2, 1'b0, 32'h17C0_0BE0, 32'h0,
           32'h02F8_017C, 1'b1, 1'b1);
    window("R2 exact ignores inverse", 32'h17C, 3'd2, 1'b0, 32'h283, 32'h0,
           32'h0000_0283, 1'b0, 1'b0);
    window("R3 inverse accepted", 32'h17C, 3'd2, 1'b1, 32'h2830, 32'h0,
           32'h0000_0283, 1'b1, 1'b1);
    window("R1 length 7", 32'hB5, 3'd0, 1'b0, 32'hD4, 32'h0,
           32'h0000_0035, 1'b1, 1'b1);
    window("R1 length 8", 32'hABCD_EF5A, 3'd1, 1'b0, 32'h1680, 32'h0,
           32'h0000_005A, 1'b1, 1'b1);
    window("R1 length 16", 32'h1234_F0F0, 3'd3, 1'b0, 32'hF0F0, 32'h0,
           32'h0000_F0F0, 1'b1, 1'b1);
    window("R1 length 20", 32'h0009_ABCD, 3'd4, 1'b0, 32'h009A_BCD0, 32'h0,
           32'h0009_ABCD, 1'b1, 1'b1);
    window("R1 code 7 uses 32 bits", 32'hFFFF_F17C, 3'd7, 1'b0, 32'h17C, 32'h0,
           32'h0000_017C, 1'b0, 1'b0);
    window("R1 length 32", 32'hDEAD_BEEF, 3'd5, 1'b0, 32'hADBE_EF00, 32'hDE,
           32'hDEAD_BEEF, 1'b1, 1'b1);

    beat(32'h1234_5678, 1'b0, 1'b1);
    check("R10 realign while idle", 32'hDEAD_BEEF, 1'b0, 1'b0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule